// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which frequency word steers the digitally controlled oscillator of a digital PLL. It moves through four modes. In Free-Run a fixed nominal word drives the oscillator, so the output depends on the system clock alone. In Locked the word from the loop filter passes through to the oscillator. In Holdover the oscillator runs from an averaged history of that loop word. In DCO the loop is open and a host servo writes the word directly. The loop filter is a separate block. This controller takes its word and the lock and reference flags, and presents one 48-bit control word with 48 fractional bits.

The history register is a first-order IIR average of the loop word, with a weight of 2^-AVG_SHIFT (1/16 by default). It is seeded with the first sample taken. It is updated only while Locked with lock detect high, and only after lock detect has stayed high for MIN_LOCK consecutive cycles. A host DCO request takes priority over every automatic transition until the host releases it.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: During and after reset the mode output is Free-Run (code 0) and the control word equals NOMINAL_WORD. The mode codes are Free-Run 0, Locked 1, Holdover 2 and DCO 3.
- R2: In Free-Run, the mode becomes Locked on the clock edge where refValid and lockDet are both high. With refValid high and lockDet low, the mode stays Free-Run.
- R3: In Locked, the control word equals loopWord in the same cycle.
- R4: In Locked, when refValid is low at a clock edge, the mode becomes Holdover if a history exists and Free-Run otherwise.
- R5: The first history capture loads loopWord exactly. Each later capture sets the history to hist + ((loopWord - hist) >>> AVG_SHIFT), using signed arithmetic. The history stays valid until reset.
- R6: In Holdover, the control word equals the stored history. When refValid and lockDet are both high at an edge, the mode becomes Locked.
- R7: With hostDcoReq high at an edge, the mode becomes DCO from any mode. While in DCO, the control word equals hostDcoWord, and changes on refValid or lockDet do not change the mode.
- R8: When hostDcoReq is low at an edge while in DCO, the mode becomes Locked if refValid is high. Otherwise it becomes Holdover if a history exists, and Free-Run if not.
- R9: In Free-Run, the control word equals NOMINAL_WORD.
- R10: History captures happen only in Locked with lockDet high, and only after MIN_LOCK consecutive such cycles. Any cycle with lockDet low restarts that count, and while lockDet is low the history is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refValid | input | 1 | Selected reference is qualified |
| lockDet | input | 1 | Loop reports phase lock |
| hostDcoReq | input | 1 | Host requests open-loop DCO mode |
| hostDcoWord | input | WORD_W | Host-written frequency word used in DCO |
| loopWord | input | WORD_W | Frequency word from the loop filter |
| oscWord | output | WORD_W | Oscillator control word |
| opMode | output | 2 | Current mode code |

## Verification
The hardest result to reach from the ports is the exact arithmetic of a single IIR step, because the history is only visible in Holdover. The stimulus first waits out the minimum lock time with a constant word, so that the history equals that word. It then applies a stepped loop word for exactly one edge. On the next negative edge it drops refValid and lockDet together, which stops any further capture. The Holdover word then shows the result of one upward step and one downward step, which also exercises the arithmetic shift of a negative difference. A separate case drops the reference before the minimum lock time has elapsed, and checks that the controller falls to Free-Run rather than Holdover.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_LOCK = 2'd1,
    MODE_HOLD = 2'd2,
    MODE_DCO  = 2'd3
  } mode_t;

  // strobes from control to datapath
  typedef struct packed {
    mode_t outSel;
    logic  histStep;
  } dpStrobe_t;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
#(
  parameter int MIN_LOCK = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refValid,
  input  logic      lockDet,
  input  logic      hostDcoReq,
  input  logic      histValid,
  output dpStrobe_t strobe,
  output mode_t     mode
);
  localparam int CNT_W = $clog2(MIN_LOCK + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOCK);

  mode_t nextMode;
  logic [CNT_W-1:0] lockCnt;

  always_comb begin
    nextMode = mode;
    if (hostDcoReq) begin
      nextMode = MODE_DCO;
    end else begin
      case (mode)
        MODE_FREE: if (refValid && lockDet) nextMode = MODE_LOCK;
        MODE_LOCK: if (!refValid) nextMode = histValid ? MODE_HOLD : MODE_FREE;
        MODE_HOLD: if (refValid && lockDet) nextMode = MODE_LOCK;
        MODE_DCO:  nextMode = refValid ? MODE_LOCK : (histValid ? MODE_HOLD : MODE_FREE);
        default:   nextMode = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_FREE;
      lockCnt <= '0;
    end else begin
      mode <= nextMode;
      if (mode == MODE_LOCK && lockDet) begin
        if (lockCnt != CNT_MAX) lockCnt <= lockCnt + 1'b1;
      end else begin
        lockCnt <= '0;
      end
    end
  end

  always_comb begin
    strobe.outSel   = mode;
    strobe.histStep = (mode == MODE_LOCK) && lockDet && (lockCnt == CNT_MAX);
  end

  assert_dco_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostDcoReq |=> mode == MODE_DCO);

  assert_lock_loss_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LOCK && !refValid && !hostDcoReq)
      |=> mode == ($past(histValid) ? MODE_HOLD : MODE_FREE));

  assert_dco_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DCO && !hostDcoReq && refValid) |=> mode == MODE_LOCK);

  assert_free_stay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_FREE && !hostDcoReq && !(refValid && lockDet)) |=> mode == MODE_FREE);
endmodule

// File: rtl/dpll_mode_dp.sv
module dpll_mode_dp
  import dpll_mode_pkg::*;
#(
  parameter int                WORD_W       = 48,
  parameter int                AVG_SHIFT    = 4,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] loopWord,
  input  logic [WORD_W-1:0] hostDcoWord,
  output logic              histValid,
  output logic [WORD_W-1:0] oscWord
);
  localparam int EXT_W = WORD_W + 1;

  logic [WORD_W-1:0] histWord;
  logic signed [EXT_W-1:0] diff, step, sum;

  always_comb begin
    diff = $signed({1'b0, loopWord}) - $signed({1'b0, histWord});
    step = diff >>> AVG_SHIFT;
    sum  = $signed({1'b0, histWord}) + step;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histWord  <= '0;
      histValid <= 1'b0;
    end else if (strobe.histStep) begin
      histWord  <= histValid ? sum[WORD_W-1:0] : loopWord;
      histValid <= 1'b1;
    end
  end

  always_comb begin
    case (strobe.outSel)
      MODE_LOCK: oscWord = loopWord;
      MODE_HOLD: oscWord = histWord;
      MODE_DCO:  oscWord = hostDcoWord;
      default:   oscWord = NOMINAL_WORD;
    endcase
  end

  assert_hist_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.histStep |=> $stable(histWord));

  assert_hist_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(histValid) |-> histValid);
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int                WORD_W       = 48,
  parameter int                AVG_SHIFT    = 4,
  parameter int                MIN_LOCK     = 16,
  parameter logic [WORD_W-1:0] NOMINAL_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refValid,
  input  logic              lockDet,
  input  logic              hostDcoReq,
  input  logic [WORD_W-1:0] hostDcoWord,
  input  logic [WORD_W-1:0] loopWord,
  output logic [WORD_W-1:0] oscWord,
  output logic [1:0]        opMode
);
  dpStrobe_t strobe;
  mode_t     mode;
  logic      histValid;

  dpll_mode_fsm #(.MIN_LOCK(MIN_LOCK)) i_fsm (
    .clk(clk), .rstN(rstN), .refValid(refValid), .lockDet(lockDet),
    .hostDcoReq(hostDcoReq), .histValid(histValid), .strobe(strobe), .mode(mode)
  );

  dpll_mode_dp #(.WORD_W(WORD_W), .AVG_SHIFT(AVG_SHIFT), .NOMINAL_WORD(NOMINAL_WORD)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loopWord(loopWord),
    .hostDcoWord(hostDcoWord), .histValid(histValid), .oscWord(oscWord)
  );

  assign opMode = mode;
endmodule

// File: tb/test_dpll_mode_ctrl.sv
`timescale 1ns/1ps
module test_dpll_mode_ctrl;
  localparam logic [47:0] NOM  = 48'h8000_0000_0000;
  localparam logic [47:0] BASE = 48'h1234_5678_9ABC;
  localparam logic [47:0] OTHR = 48'h0AAA_BBBB_CCCC;
  localparam logic [47:0] HWRD = 48'h7FFF_0000_1111;

  logic clk = 1'b0, rstN = 1'b0;
  logic refValid = 1'b0, lockDet = 1'b0, hostDcoReq = 1'b0;
  logic [47:0] hostDcoWord = '0, loopWord = '0, oscWord;
  logic [1:0] opMode;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpll_mode_ctrl i_dpll_mode_ctrl (
    .clk(clk), .rstN(rstN), .refValid(refValid), .lockDet(lockDet),
    .hostDcoReq(hostDcoReq), .hostDcoWord(hostDcoWord), .loopWord(loopWord),
    .oscWord(oscWord), .opMode(opMode)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; refValid = 1'b0; lockDet = 1'b0; hostDcoReq = 1'b0;
    loopWord = BASE; hostDcoWord = HWRD;
    steps(2);
    chk("R1 mode", 48'(opMode), 48'd0);
    chk("R1 word", oscWord, NOM);
    rstN = 1'b1;
    steps(1);
  endtask

  task automatic testFreeRun();
    refValid = 1'b1; lockDet = 1'b0;
    steps(5);
    chk("R2 stay free", 48'(opMode), 48'd0);
    chk("R9 nominal", oscWord, NOM);
  endtask

  task automatic testEarlyLoss();
    refValid = 1'b1; lockDet = 1'b1; loopWord = BASE;
    steps(1);
    chk("R2 to locked", 48'(opMode), 48'd1);
    chk("R3 loop word", oscWord, BASE);
    steps(7);
    refValid = 1'b0; lockDet = 1'b0;
    steps(1);
    chk("R4 no history free", 48'(opMode), 48'd0);
    chk("R10 no early capture", oscWord, NOM);
  endtask

  task automatic testHoldoverIir();
    refValid = 1'b1; lockDet = 1'b1; loopWord = BASE;
    steps(20);
    loopWord = BASE + 48'd160;
    steps(1);
    refValid = 1'b0; lockDet = 1'b0; loopWord = OTHR;
    steps(1);
    chk("R4 to holdover", 48'(opMode), 48'd2);
    chk("R5 up step", oscWord, BASE + 48'd10);
    refValid = 1'b1; lockDet = 1'b1; loopWord = BASE + 48'd10;
    steps(1);
    chk("R6 relock", 48'(opMode), 48'd1);
    steps(19);
    loopWord = BASE + 48'd10 - 48'd32;
    steps(1);
    refValid = 1'b0; lockDet = 1'b0;
    steps(1);
    chk("R5 down step", oscWord, BASE + 48'd8);
  endtask

  task automatic testLockDrop();
    refValid = 1'b1; lockDet = 1'b1; loopWord = BASE + 48'd8;
    steps(1);
    lockDet = 1'b0; loopWord = OTHR;
    steps(30);
    chk("R10 locked with lockDet low", 48'(opMode), 48'd1);
    chk("R3 passthrough", oscWord, OTHR);
    refValid = 1'b0;
    steps(1);
    chk("R10 history unchanged", oscWord, BASE + 48'd8);
  endtask

  task automatic testDco();
    hostDcoReq = 1'b1;
    steps(1);
    chk("R7 enter dco", 48'(opMode), 48'd3);
    chk("R7 host word", oscWord, HWRD);
    refValid = 1'b1; lockDet = 1'b1;
    steps(4);
    refValid = 1'b0;
    steps(2);
    chk("R7 ignores ref", 48'(opMode), 48'd3);
    refValid = 1'b1; hostDcoReq = 1'b0;
    steps(1);
    chk("R8 release to locked", 48'(opMode), 48'd1);
    hostDcoReq = 1'b1;
    steps(1);
    refValid = 1'b0; lockDet = 1'b0; hostDcoReq = 1'b0;
    steps(1);
    chk("R8 release to holdover", 48'(opMode), 48'd2);
    chk("R6 holdover word", oscWord, BASE + 48'd8);
  endtask

  task automatic testDcoNoHistory();
    hostDcoReq = 1'b1;
    steps(2);
    chk("R7 dco from free", 48'(opMode), 48'd3);
    hostDcoReq = 1'b0;
    steps(1);
    chk("R8 release to free", 48'(opMode), 48'd0);
    chk("R9 nominal after release", oscWord, NOM);
  endtask

  initial begin
    doReset();
    testFreeRun();
    testEarlyLoss();
    testHoldoverIir();
    testLockDrop();
    testDco();
    doReset();
    testDcoNoHistory();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule